// File: doc/BRIEF.md
# Dual Conditional-Access Slot Controller

This block sits between a host register port and two removable conditional-access card slots. The host reaches it through a small indirect register set. Two registers hold a card byte address, which is always even. A bus control register picks the target slot and the space (attribute memory or control space). An access to the data register then runs one byte cycle on a shared card bus. A card-side wait input stretches that cycle, and the host's ready output stays low until the card releases wait.

The same bus control register carries the per-slot control bits and the card-detect status:

- Each slot has a self-clearing reset request. Writing 1 starts a reset sequencer (states RS_IDLE, RS_HOLD, RS_SETTLE).
  - RS_IDLE moves to RS_HOLD on a start request.
  - RS_HOLD drives the slot reset output for a programmable number of clocks, then moves to RS_SETTLE.
  - RS_SETTLE moves back to RS_IDLE when the card reports ready or a timeout expires.
- Each slot has a transport-stream routing enable.
- The synchronised active-low card-detect inputs can be read back.

The card bus sequencer has two states. BC_IDLE moves to BC_ACCESS on a data-register access. BC_ACCESS returns to BC_IDLE in the first cycle in which wait is low.

An auxiliary register drives two transport-output enables and two active-low tuner reset lines. An interrupt register holds the card-detect interrupt enable. A change on either synchronised card-detect input sets a pending interrupt while the enable is on. Reading the interrupt register acknowledges the pending interrupt.

Top module: `ca_dual_slot_ctrl`

## Requirements
- R1: After reset every output is 0 (tuner_rst_n included), the interrupt is disabled and not pending, and with both detect inputs high the bus control register reads 0x03.
- R2: Register offsets: 0 interrupt, 1 auxiliary, 2 address low, 3 address high, 4 data, 5 bus control. Other offsets read 0 and ignore writes. A register access other than data raises hst_ready exactly one cycle after the select.
- R3: Address low keeps bits 7:1 and always reads bit 0 as 0. Address high keeps bits 6:0 and reads bit 7 as 0. card_addr is {address high[6:0], address low[7:1], 0}.
- R4: In bus control, bit 7 selects the slot and bit 6 selects control space (1) or attribute memory (0). These drive card_slot and card_space.
- R5: Bus control bit 3 drives ts_route_en[0] and bit 2 drives ts_route_en[1].
- R6: Writing 1 to bus control bit 5 (slot 0) or bit 4 (slot 1) drives slot_rst of that slot high for exactly RST_HOLD cycles. The bit reads 1 until the slot's card_ready is high after the hold phase, or until RST_TIMEOUT cycles of the settle phase have passed. Writing 0 to the bit has no effect.
- R7: Bus control bit 1 reads the synchronised card-detect of slot 0 and bit 0 that of slot 1 (0 = card present). Writes to these bits are ignored.
- R8: A data register access raises card_strb for one byte cycle, with card_wr and card_wdata taken from the host access. card_strb stays high while card_wait is high. hst_ready rises 2 + (wait cycles) cycles after the select.
- R9: A data register read returns the byte present on card_rdata in the last strobe cycle.
- R10: The interrupt is enabled only when the last write to the interrupt register had both bit 6 and bit 2 set (value 0x44). While enabled, any change of a synchronised card-detect input sets the pending flag, and irq follows that flag.
- R11: Reading the interrupt register returns the pending flag in bit 0 and the enable in bits 6 and 2, and clears the pending flag.
- R12: In the auxiliary register:
  - bit 4 drives ts_out_en[0] and bit 5 drives ts_out_en[1];
  - bit 2 drives tuner_rst_n[0] and bit 3 drives tuner_rst_n[1];
  - the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | One-cycle register access request |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 4 | Register offset |
| hst_wdata | input | 8 | Write data |
| hst_rdata | output | 8 | Read data, valid while hst_ready is high |
| hst_ready | output | 1 | Access complete pulse |
| card_strb | output | 1 | Card byte cycle active |
| card_wr | output | 1 | Card cycle direction |
| card_slot | output | 1 | Target slot |
| card_space | output | 1 | 1 = control space, 0 = attribute memory |
| card_addr | output | 15 | Card byte address (even) |
| card_wdata | output | 8 | Card write data |
| card_rdata | input | 8 | Card read data |
| card_wait | input | 1 | Card stretches the cycle while high |
| card_ready | input | 2 | Per-slot card finished reset |
| cd_n | input | 2 | Per-slot card detect, active low, asynchronous |
| slot_rst | output | 2 | Per-slot card reset |
| ts_route_en | output | 2 | Per-slot transport-stream routing enable |
| ts_out_en | output | 2 | Transport-output enables |
| tuner_rst_n | output | 2 | Active-low tuner resets |
| irq | output | 1 | Card-detect interrupt pending |

## Verification
The card byte cycle is exercised with random even addresses, both slots, both spaces, reads and writes, and zero to three wait cycles. Comparing the captured card-side address and controls tells address packing apart from slot and space selection. The ready latency shows whether wait stretching is honoured. The read data, computed by a bench function from address, slot and space, exposes any mix-up between those three fields. Directed cases separate the two ways a slot reset ends (card ready versus timeout), interrupt enable versus disable, and acknowledge-by-read versus a plain read of another register.

// File: rtl/ca_slot_pkg.sv
package ca_slot_pkg;
    localparam logic [3:0] OFS_IRQ     = 4'd0;
    localparam logic [3:0] OFS_AUX     = 4'd1;
    localparam logic [3:0] OFS_ADDR_LO = 4'd2;
    localparam logic [3:0] OFS_ADDR_HI = 4'd3;
    localparam logic [3:0] OFS_DATA    = 4'd4;
    localparam logic [3:0] OFS_BUSCTL  = 4'd5;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HOLD,
        RS_SETTLE
    } rst_state_t;

    typedef enum logic {
        BC_IDLE,
        BC_ACCESS
    } bus_state_t;
endpackage

// File: rtl/ca_cd_sync.sv
module ca_cd_sync #(
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] cd_n_i,
    output logic [SLOTS-1:0] cd_n_o,
    output logic             edge_o
);
    logic [SLOTS-1:0] meta_q;
    logic [SLOTS-1:0] sync_q;
    logic [SLOTS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= cd_n_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cd_n_o = sync_q;
    assign edge_o = |(sync_q ^ prev_q);

    // R7 / R10: a reported change must come from the synchroniser pipeline
    a_r7_edge_from_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> $past(meta_q != sync_q));
endmodule

// File: rtl/ca_slot_reset_seq.sv
module ca_slot_reset_seq
    import ca_slot_pkg::*;
#(
    parameter int RST_HOLD    = 16,
    parameter int RST_TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    output logic rst_o,
    output logic busy_o
);
    localparam int CNT_MAX = (RST_HOLD > RST_TIMEOUT) ? RST_HOLD : RST_TIMEOUT;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(RST_TIMEOUT - 1);

    rst_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:   if (start_i) state_d = RS_HOLD;
            RS_HOLD:   if (cnt_q == HOLD_LAST) state_d = RS_SETTLE;
            RS_SETTLE: if (ready_i || cnt_q == TMO_LAST) state_d = RS_IDLE;
            default:   state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == RS_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rst_o  = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            RS_IDLE:   busy_o = 1'b0;
            RS_HOLD:   rst_o  = 1'b1;
            RS_SETTLE: rst_o  = 1'b0;
            default:   busy_o = 1'b0;
        endcase
    end

    // R6: reset output only starts from a request
    a_r6_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(start_i));
    // R6: reset output is not cut short
    a_r6_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_o && cnt_q != HOLD_LAST) |=> rst_o);
    // R6: settle phase stays busy until ready or timeout
    a_r6_settle_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_SETTLE && !ready_i && cnt_q != TMO_LAST) |=> busy_o);
endmodule

// File: rtl/ca_bus_cycle.sv
module ca_bus_cycle
    import ca_slot_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wait_i,
    input  logic [DW-1:0] rdata_i,
    output logic          strb_o,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    bus_state_t    state_q, state_d;
    logic          wr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BC_IDLE:   if (start_i) state_d = BC_ACCESS;
            BC_ACCESS: if (!wait_i) state_d = BC_IDLE;
            default:   state_d = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == BC_ACCESS) && !wait_i;
            if (state_q == BC_IDLE && start_i) begin
                wr_q    <= wr_i;
                wdata_q <= wdata_i;
            end
            if (state_q == BC_ACCESS && !wait_i)
                rdata_q <= rdata_i;
        end
    end

    always_comb begin
        strb_o = 1'b0;
        unique case (state_q)
            BC_IDLE:   strb_o = 1'b0;
            BC_ACCESS: strb_o = 1'b1;
            default:   strb_o = 1'b0;
        endcase
    end

    assign wr_o    = wr_q;
    assign wdata_o = wdata_q;
    assign done_o  = done_q;
    assign rdata_o = rdata_q;

    // R8: the card keeps the strobe while it asserts wait
    a_r8_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_o && wait_i) |=> strb_o);
    // R8: completion only after a released strobe cycle
    a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(strb_o && !wait_i));
    // R8: write data stable through the cycle
    a_r8_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_o && wait_i) |=> $stable(wdata_o));
endmodule

// File: rtl/ca_dual_slot_ctrl.sv
module ca_dual_slot_ctrl
    import ca_slot_pkg::*;
#(
    parameter int RST_HOLD    = 16,
    parameter int RST_TIMEOUT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_sel,
    input  logic        hst_wr,
    input  logic [3:0]  hst_addr,
    input  logic [7:0]  hst_wdata,
    output logic [7:0]  hst_rdata,
    output logic        hst_ready,
    output logic        card_strb,
    output logic        card_wr,
    output logic        card_slot,
    output logic        card_space,
    output logic [14:0] card_addr,
    output logic [7:0]  card_wdata,
    input  logic [7:0]  card_rdata,
    input  logic        card_wait,
    input  logic [1:0]  card_ready,
    input  logic [1:0]  cd_n,
    output logic [1:0]  slot_rst,
    output logic [1:0]  ts_route_en,
    output logic [1:0]  ts_out_en,
    output logic [1:0]  tuner_rst_n,
    output logic        irq
);
    localparam int SLOTS = 2;

    logic [6:0] addr_lo_q;
    logic [6:0] addr_hi_q;
    logic       slot_q;
    logic       space_q;
    logic [1:0] route_q;
    logic [3:0] aux_q;
    logic       irq_en_q;
    logic       irq_pend_q;
    logic [7:0] rdata_q;
    logic       rdy_q;

    logic             acc;
    logic             reg_acc;
    logic             reg_wr;
    logic             reg_rd;
    logic             bus_start;
    logic             bus_done;
    logic [7:0]       bus_rdata;
    logic [SLOTS-1:0] cd_sync_n;
    logic             cd_edge;
    logic [SLOTS-1:0] rst_busy;
    logic [SLOTS-1:0] rst_start;
    logic             irq_ack;
    logic             irq_set;
    logic [7:0]       rd_mux;

    assign acc       = hst_sel && !card_strb;
    assign reg_acc   = acc && (hst_addr != OFS_DATA);
    assign reg_wr    = reg_acc && hst_wr;
    assign reg_rd    = reg_acc && !hst_wr;
    assign bus_start = acc && (hst_addr == OFS_DATA);
    assign irq_ack   = reg_rd && (hst_addr == OFS_IRQ);
    assign irq_set   = irq_en_q && cd_edge;

    // slot 0 reset request is bit 5, slot 1 is bit 4
    assign rst_start[0] = reg_wr && (hst_addr == OFS_BUSCTL) && hst_wdata[5];
    assign rst_start[1] = reg_wr && (hst_addr == OFS_BUSCTL) && hst_wdata[4];

    ca_cd_sync #(.SLOTS(SLOTS)) u_cd_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cd_n_i (cd_n),
        .cd_n_o (cd_sync_n),
        .edge_o (cd_edge)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ca_slot_reset_seq #(
            .RST_HOLD    (RST_HOLD),
            .RST_TIMEOUT (RST_TIMEOUT)
        ) u_rst_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (rst_start[s]),
            .ready_i (card_ready[s]),
            .rst_o   (slot_rst[s]),
            .busy_o  (rst_busy[s])
        );
    end

    ca_bus_cycle #(.DW(8)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (bus_start),
        .wr_i    (hst_wr),
        .wdata_i (hst_wdata),
        .wait_i  (card_wait),
        .rdata_i (card_rdata),
        .strb_o  (card_strb),
        .wr_o    (card_wr),
        .wdata_o (card_wdata),
        .done_o  (bus_done),
        .rdata_o (bus_rdata)
    );

    always_comb begin
        unique case (hst_addr)
            OFS_IRQ:     rd_mux = {1'b0, irq_en_q, 3'b000, irq_en_q, 1'b0, irq_pend_q};
            OFS_AUX:     rd_mux = {2'b00, aux_q, 2'b00};
            OFS_ADDR_LO: rd_mux = {addr_lo_q, 1'b0};
            OFS_ADDR_HI: rd_mux = {1'b0, addr_hi_q};
            OFS_BUSCTL:  rd_mux = {slot_q, space_q, rst_busy[0], rst_busy[1],
                                   route_q[0], route_q[1], cd_sync_n[0], cd_sync_n[1]};
            default:     rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q  <= '0;
            addr_hi_q  <= '0;
            slot_q     <= 1'b0;
            space_q    <= 1'b0;
            route_q    <= '0;
            aux_q      <= '0;
            irq_en_q   <= 1'b0;
            irq_pend_q <= 1'b0;
            rdata_q    <= '0;
            rdy_q      <= 1'b0;
        end else begin
            rdy_q      <= reg_acc;
            irq_pend_q <= irq_set || (irq_pend_q && !irq_ack);
            if (reg_acc)
                rdata_q <= hst_wr ? 8'h00 : rd_mux;
            if (reg_wr) begin
                unique case (hst_addr)
                    OFS_IRQ:     irq_en_q  <= hst_wdata[6] && hst_wdata[2];
                    OFS_AUX:     aux_q     <= hst_wdata[5:2];
                    OFS_ADDR_LO: addr_lo_q <= hst_wdata[7:1];
                    OFS_ADDR_HI: addr_hi_q <= hst_wdata[6:0];
                    OFS_BUSCTL: begin
                        slot_q     <= hst_wdata[7];
                        space_q    <= hst_wdata[6];
                        route_q[0] <= hst_wdata[3];
                        route_q[1] <= hst_wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hst_ready   = rdy_q || bus_done;
    assign hst_rdata   = bus_done ? bus_rdata : rdata_q;
    assign card_slot   = slot_q;
    assign card_space  = space_q;
    assign card_addr   = {addr_hi_q, addr_lo_q, 1'b0};
    assign ts_route_en = route_q;
    assign ts_out_en   = aux_q[3:2];
    assign tuner_rst_n = aux_q[1:0];
    assign irq         = irq_pend_q;

    // R10: pending only rises while enabled
    a_r10_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en_q));
    // R11: a read of the interrupt register acknowledges
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_set) |=> !irq);
    // R2: plain register access completes in one cycle
    a_r2_reg_ready: assert property (@(posedge clk) disable iff (!rst_n)
        reg_acc |=> hst_ready);
    // R3: the card address is held steady through a stretched cycle
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (card_strb && card_wait) |=> $stable(card_addr));
endmodule

// File: tb/test_ca_dual_slot_ctrl.sv
module test_ca_dual_slot_ctrl;
    localparam int HOLD = 6;
    localparam int TMO  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0, hst_wr = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        hst_ready;
    logic        card_strb, card_wr, card_slot, card_space;
    logic [14:0] card_addr;
    logic [7:0]  card_wdata, card_rdata;
    logic        card_wait = 1'b0;
    logic [1:0]  card_ready = 2'b00;
    logic [1:0]  cd_n = 2'b11;
    logic [1:0]  slot_rst, ts_route_en, ts_out_en, tuner_rst_n;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int wait_req = 0;
    int wait_cnt = 0;
    logic        prev_strb = 1'b0;
    logic [14:0] cap_addr = '0;
    logic        cap_slot = 1'b0, cap_space = 1'b0, cap_wr = 1'b0;
    logic [7:0]  cap_wdata = '0;

    always #4 clk = ~clk;

    ca_dual_slot_ctrl #(.RST_HOLD(HOLD), .RST_TIMEOUT(TMO)) i_ca_dual_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_ready(hst_ready), .card_strb(card_strb), .card_wr(card_wr),
        .card_slot(card_slot), .card_space(card_space), .card_addr(card_addr),
        .card_wdata(card_wdata), .card_rdata(card_rdata), .card_wait(card_wait),
        .card_ready(card_ready), .cd_n(cd_n), .slot_rst(slot_rst),
        .ts_route_en(ts_route_en), .ts_out_en(ts_out_en),
        .tuner_rst_n(tuner_rst_n), .irq(irq));

    function automatic logic [7:0] card_byte(logic [14:0] a, logic s, logic sp);
        return a[7:0] ^ {1'b0, a[14:8]} ^ {s, sp, 6'h15};
    endfunction

    assign card_rdata = card_byte(card_addr, card_slot, card_space);

    // card model: wait for wait_req cycles, capture the cycle's first beat
    always @(negedge clk) begin
        prev_strb <= card_strb;
        if (!card_strb) begin
            wait_cnt  <= wait_req;
            card_wait <= 1'b0;
        end else if (wait_cnt != 0) begin
            card_wait <= 1'b1;
            wait_cnt  <= wait_cnt - 1;
        end else begin
            card_wait <= 1'b0;
        end
        if (card_strb && !prev_strb) begin
            cap_addr  <= card_addr;
            cap_slot  <= card_slot;
            cap_space <= card_space;
            cap_wr    <= card_wr;
            cap_wdata <= card_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
        hst_sel = 1'b1; hst_wr = wr; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_sel = 1'b0;
        lat = 1;
        while (!hst_ready && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        rd = hst_rdata;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] rd; int lat;
        acc(1'b1, a, d, rd, lat);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] rd);
        int lat;
        acc(1'b0, a, 8'h00, rd, lat);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int lat, cnt;
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", {hst_ready, card_strb, slot_rst, ts_route_en, ts_out_en, tuner_rst_n, irq},
            12'h000);
        rd_reg(4'd5, rd); chk("R1 busctl", rd, 8'h03);
        rd_reg(4'd0, rd); chk("R1 irq reg", rd, 8'h00);

        // R2 latency and unmapped offset
        acc(1'b0, 4'd3, 8'h00, rd, lat); chk("R2 reg latency", lat, 1);
        wr_reg(4'd9, 8'hff); rd_reg(4'd9, rd); chk("R2 unmapped", rd, 8'h00);

        // R3 address packing
        wr_reg(4'd2, 8'hff); rd_reg(4'd2, rd); chk("R3 addr lo", rd, 8'hfe);
        wr_reg(4'd3, 8'hff); rd_reg(4'd3, rd); chk("R3 addr hi", rd, 8'h7f);
        chk("R3 card_addr", card_addr, 15'h7ffe);

        // R4 R8 R9 random card cycles
        for (int i = 0; i < 40; i++) begin
            logic [14:0] a;
            logic s, sp, w;
            logic [7:0] d;
            int wc;
            a  = 15'($urandom) & 15'h7ffe;
            s  = 1'($urandom);
            sp = 1'($urandom);
            w  = 1'($urandom);
            d  = 8'($urandom);
            wc = (i < 4) ? i : int'($urandom % 4);
            wr_reg(4'd2, a[7:0]);
            wr_reg(4'd3, {1'b0, a[14:8]});
            wr_reg(4'd5, {s, sp, 6'b0});
            wait_req = wc;
            @(negedge clk);
            acc(w, 4'd4, d, rd, lat);
            chk("R3 cycle addr", cap_addr, a);
            chk("R4 slot/space", {cap_slot, cap_space}, {s, sp});
            chk("R8 latency", lat, 2 + wc);
            chk("R8 direction", cap_wr, w);
            if (w) chk("R8 wdata", cap_wdata, d);
            else   chk("R9 rdata", rd, card_byte(a, s, sp));
        end
        wait_req = 0;

        // R5 routing
        wr_reg(4'd5, 8'h08); chk("R5 route slot0", ts_route_en, 2'b01);
        wr_reg(4'd5, 8'h04); chk("R5 route slot1", ts_route_en, 2'b10);

        // R12 auxiliary
        wr_reg(4'd1, 8'hff); rd_reg(4'd1, rd); chk("R12 readback", rd, 8'h3c);
        chk("R12 outputs", {ts_out_en, tuner_rst_n}, 4'hf);
        wr_reg(4'd1, 8'h14);
        chk("R12 bit map", {ts_out_en, tuner_rst_n}, 4'b0101);

        // R6 slot 0: hold length, ignored zero write, ready release
        wr_reg(4'd5, 8'h00);
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = 4'd5; hst_wdata = 8'h20;
        @(negedge clk); hst_sel = 1'b0;
        cnt = 0;
        while (slot_rst[0] && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R6 hold cycles", cnt, HOLD);
        chk("R6 other slot idle", slot_rst[1], 1'b0);
        wr_reg(4'd5, 8'h00);
        rd_reg(4'd5, rd); chk("R6 busy while settle", rd[5], 1'b1);
        card_ready[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd_reg(4'd5, rd); chk("R6 clear on ready", rd[5], 1'b0);

        // R6 slot 1: timeout release
        wr_reg(4'd5, 8'h10);
        repeat (HOLD + TMO - 5) @(negedge clk);
        rd_reg(4'd5, rd); chk("R6 busy before timeout", rd[4], 1'b1);
        repeat (10) @(negedge clk);
        rd_reg(4'd5, rd); chk("R6 clear after timeout", rd[4], 1'b0);

        // R10 R11 interrupt enabled, detect slot0
        wr_reg(4'd0, 8'h44);
        cd_n[0] = 1'b0;
        cnt = 0;
        while (!irq && cnt < 8) begin @(negedge clk); cnt++; end
        chk("R10 irq on insert", irq, 1'b1);
        rd_reg(4'd5, rd); chk("R7 detect slot0", rd[1:0], 2'b01);
        wr_reg(4'd5, 8'h03); rd_reg(4'd5, rd); chk("R7 detect not writable", rd[1:0], 2'b01);
        chk("R11 irq kept by other read", irq, 1'b1);
        rd_reg(4'd0, rd); chk("R11 read value", rd, 8'h45);
        chk("R11 ack clears", irq, 1'b0);
        rd_reg(4'd0, rd); chk("R11 second read", rd, 8'h44);

        // R10 disabled when only bit 2 set
        wr_reg(4'd0, 8'h04);
        cd_n[1] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10 disabled no irq", irq, 1'b0);
        rd_reg(4'd0, rd); chk("R10 enable off", rd, 8'h00);
        rd_reg(4'd5, rd); chk("R7 detect slot1", rd[1:0], 2'b00);

        // R10 removal edge with enable
        wr_reg(4'd0, 8'h44);
        cd_n[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 irq on removal", irq, 1'b1);

        finish_run();
    end
endmodule